// File: doc/BRIEF.md
# Strided Vector Gather Scheduler

This block services one vector load at a time. A request carries a base word address, a signed stride and an element count. The block walks the address sequence base, base+stride, base+2·stride and so on, and sends at most one element read per cycle to a set of interleaved single-port banks. Each bank stays occupied for a fixed number of cycles after a read starts. An element whose bank is still occupied waits, and the elements behind it wait too. Each read returns its word after a fixed latency on a write-back port, tagged with the element number.

The request side is a valid/ready handshake. The block takes a request on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the run finishes, so no request can be queued while a run is active. The write-back port has no ready signal because it behaves like a register-file write port that always accepts. All back-pressure is therefore applied at the request side. A single-cycle `done` pulse marks the end of each run.

The banks are built in as synchronous arrays and have no write port. Every word holds a fixed pattern derived from its own address.

Top module: `vec_bank_sched`

## Requirements
- R1: `req_ready` is high whenever no run is active. A request is taken on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is low from that edge until the cycle in which `done` is high. A request offered while `req_ready` is low is ignored and changes no output.
- R2: Element i reads word address (base + i·stride) modulo 2^ADDR_W, where stride is two's complement. The bank is the low 4 address bits and the row is the remaining bits.
- R3: At most one element issues per cycle. Two reads to the same bank start at least 4 clock edges apart. An element that would break this spacing waits, and all later elements wait behind it.
- R4: An element that issues at clock edge k appears on the write-back port right after edge k+11. Element 0 issues at the first edge after the accept edge, and each later element issues as early as R3 allows. With no conflicts, element i appears 12+i edges after the accept edge.
- R5: Write-backs come in element order, at most one per cycle, with `wb_idx` equal to the element number.
- R6: The word at address a has its low 32 bits equal to a zero-extended, and its high 32 bits equal to the bitwise inverse of the low 32 bits.
- R7: `done` is high for exactly the one cycle after the last write-back, and `req_ready` rises in that same cycle.
- R8: A request with length zero makes no write-back. It pulses `done` in the cycle right after the accept edge, and `req_ready` stays high.
- R9: A requested length above 64 is treated as 64.
- R10: A stride that is a multiple of 16, including zero, keeps hitting one bank. Its write-backs are spaced exactly 4 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_base | input | ADDR_W (10) | Word address of element 0 |
| req_stride | input | ADDR_W (10) | Signed element stride in words |
| req_vlen | input | 7 | Element count, 0 to 64 (larger values clamp) |
| wb_valid | output | 1 | Write-back element present |
| wb_idx | output | 6 | Element number of the write-back |
| wb_data | output | 64 | Element data |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The return of an earlier element and the stall of a later element on a busy bank often fall in the same cycle. Stride 8 (banks alternate between two values), stride 16 and stride 0 all provoke this overlap, while small strides that never conflict serve as the baseline. The bench runs a cycle model of the bank spacing rule to predict each element's issue edge. It stamps every write-back with the number of edges since the accept edge and compares that stamp, the index and the data against the model. A second collision is between the last write-back and a request held on `req_valid` during the run. The bench checks that the held request is not taken before `done`.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_RUN  = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/vbs_addr_gen.sv
module vbs_addr_gen #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 6,
  parameter int VLEN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [VLEN_W-1:0] vlen,
  input  logic              bank_free,
  output logic              issue,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  logic              active_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] stride_q;
  logic [IDX_W-1:0]  idx_q;
  logic [VLEN_W-1:0] vl_q;
  logic              at_last;

  assign at_last = (VLEN_W'(idx_q) == vl_q - VLEN_W'(1));
  assign issue   = active_q && bank_free;
  assign addr    = addr_q;
  assign idx     = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
      vl_q     <= '0;
    end else if (start) begin
      active_q <= (vlen != '0);
      addr_q   <= base;
      stride_q <= stride;
      idx_q    <= '0;
      vl_q     <= vlen;
    end else if (issue) begin
      addr_q <= addr_q + stride_q;
      idx_q  <= idx_q + IDX_W'(1);
      if (at_last) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vbs_bank_busy.sv
module vbs_bank_busy #(
  parameter int NB     = 16,
  parameter int BUSY   = 4,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [BANK_W-1:0] bank,
  output logic [NB-1:0]     busy
);
  localparam int CW = $clog2(BUSY + 1);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (issue && bank == BANK_W'(g))   cnt_q <= CW'(BUSY - 1);
      else if (cnt_q != '0)                   cnt_q <= cnt_q - CW'(1);
    end

    assign busy[g] = (cnt_q != '0);

    // R3: the issue logic never starts a read on a bank whose window is open
    p_no_issue_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && bank == BANK_W'(g)) |-> (cnt_q == '0));
  end
endmodule

// File: rtl/vbs_bank_array.sv
module vbs_bank_array #(
  parameter int NB     = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ROW_W = ADDR_W - BANK_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int HALF  = DATA_W / 2;

  logic [DATA_W-1:0] bank_rd [NB];
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row;
  logic [BANK_W-1:0] sel;

  assign sel = rd_addr[BANK_W-1:0];
  assign row = rd_addr[ADDR_W-1:BANK_W];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rd_q;

    initial begin
      for (int r = 0; r < ROWS; r++) begin
        mem[r] = {~HALF'(r * NB + g), HALF'(r * NB + g)};
      end
    end

    always_ff @(posedge clk) begin
      if (rd_en && sel == BANK_W'(g)) rd_q <= mem[row];
    end

    assign bank_rd[g] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (rd_en) bank_q <= sel;
  end

  assign rd_data = bank_rd[bank_q];
endmodule

// File: rtl/vbs_return_pipe.sv
module vbs_return_pipe #(
  parameter int LAT    = 12,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] rd_data,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_data
);
  logic [LAT-1:0]    vld_q;
  logic [IDX_W-1:0]  idx_q [LAT];
  logic [DATA_W-1:0] dat_q [1:LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int j = 0; j < LAT; j++) idx_q[j] <= '0;
    end else begin
      vld_q    <= {vld_q[LAT-2:0], issue};
      idx_q[0] <= idx;
      for (int j = 1; j < LAT; j++) idx_q[j] <= idx_q[j-1];
    end
  end

  always_ff @(posedge clk) begin
    dat_q[1] <= rd_data;
    for (int j = 2; j < LAT; j++) dat_q[j] <= dat_q[j-1];
  end

  assign out_valid = vld_q[LAT-1];
  assign out_idx   = idx_q[LAT-1];
  assign out_data  = dat_q[LAT-1];
endmodule

// File: rtl/vec_bank_sched.sv
module vec_bank_sched #(
  parameter int NB     = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64,
  parameter int VMAX   = 64,
  parameter int BUSY   = 4,
  parameter int LAT    = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_base,
  input  logic [ADDR_W-1:0]           req_stride,
  input  logic [$clog2(VMAX+1)-1:0]   req_vlen,
  output logic                        wb_valid,
  output logic [$clog2(VMAX)-1:0]     wb_idx,
  output logic [DATA_W-1:0]           wb_data,
  output logic                        done
);
  import vbs_pkg::*;

  localparam int BANK_W = $clog2(NB);
  localparam int IDX_W  = $clog2(VMAX);
  localparam int VLEN_W = $clog2(VMAX + 1);

  ctl_state_e        state_q;
  logic [VLEN_W-1:0] vl_q;
  logic [VLEN_W-1:0] vl_eff;
  logic              done_q;
  logic              accept;
  logic              start;
  logic              wb_last;
  logic              issue;
  logic [ADDR_W-1:0] iss_addr;
  logic [IDX_W-1:0]  iss_idx;
  logic [NB-1:0]     bank_busy;
  logic              bank_free;
  logic [DATA_W-1:0] rd_data;

  assign req_ready = (state_q == CTL_IDLE);
  assign accept    = req_valid && req_ready;
  assign vl_eff    = (req_vlen > VLEN_W'(VMAX)) ? VLEN_W'(VMAX) : req_vlen;
  assign start     = accept && (vl_eff != '0);
  assign bank_free = !bank_busy[iss_addr[BANK_W-1:0]];
  assign wb_last   = wb_valid && (VLEN_W'(wb_idx) == vl_q - VLEN_W'(1));
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      vl_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        vl_q <= vl_eff;
        if (vl_eff == '0) done_q  <= 1'b1;
        else              state_q <= CTL_RUN;
      end else if (state_q == CTL_RUN && wb_last) begin
        done_q  <= 1'b1;
        state_q <= CTL_IDLE;
      end
    end
  end

  vbs_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VLEN_W(VLEN_W)) u_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .base(req_base),
    .stride(req_stride), .vlen(vl_eff), .bank_free(bank_free),
    .issue(issue), .addr(iss_addr), .idx(iss_idx)
  );

  vbs_bank_busy #(.NB(NB), .BUSY(BUSY), .BANK_W(BANK_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .issue(issue),
    .bank(iss_addr[BANK_W-1:0]), .busy(bank_busy)
  );

  vbs_bank_array #(.NB(NB), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_banks (
    .clk(clk), .rd_en(issue), .rd_addr(iss_addr), .rd_data(rd_data)
  );

  vbs_return_pipe #(.LAT(LAT), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .issue(issue), .idx(iss_idx), .rd_data(rd_data),
    .out_valid(wb_valid), .out_idx(wb_idx), .out_data(wb_data)
  );

  // checker state: write-backs seen since the last accepted request
  logic [IDX_W:0] wb_seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        wb_seen_q <= '0;
    else if (accept)   wb_seen_q <= '0;
    else if (wb_valid) wb_seen_q <= wb_seen_q + 1'b1;
  end

  p_wb_inorder_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((IDX_W+1)'(wb_idx) == wb_seen_q));

  p_ready_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_idx_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (VLEN_W'(wb_idx) < vl_q));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!issue && !wb_valid));
endmodule

// File: tb/vec_bank_sched_tb.sv
module vec_bank_sched_tb;
  localparam int ADDR_W = 10;
  localparam int LAT    = 12;
  localparam int BUSY   = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_base = '0;
  logic [ADDR_W-1:0] req_stride = '0;
  logic [6:0]        req_vlen = '0;
  logic              wb_valid;
  logic [5:0]        wb_idx;
  logic [63:0]       wb_data;
  logic              done;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  vec_bank_sched u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_stride(req_stride), .req_vlen(req_vlen),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] word_at(input int a);
    logic [31:0] lo;
    lo = 32'(a & ((1 << ADDR_W) - 1));
    return {~lo, lo};
  endfunction

  // One request; expected issue edges follow the bank spacing rule (R3, R4).
  task automatic run_vec(input int base, input int stride, input int vl,
                         input bit hold_junk, input string tag);
    int n;
    int exp_cnt [64];
    int last_b [16];
    int prev;
    int k;
    int last_wb;
    bit ready_bad;
    bit got_done;
    n = (vl > 64) ? 64 : vl;
    for (int b = 0; b < 16; b++) last_b[b] = -100;
    prev = 0;
    for (int i = 0; i < n; i++) begin
      int a;
      int bk;
      int t;
      a  = (base + i * stride) & ((1 << ADDR_W) - 1);
      bk = a & 15;
      t  = prev + 1;
      if (last_b[bk] + BUSY > t) t = last_b[bk] + BUSY;
      last_b[bk] = t;
      prev = t;
      exp_cnt[i] = t + LAT - 1;
    end
    @(negedge clk);
    req_base   = ADDR_W'(base);
    req_stride = ADDR_W'(stride);
    req_vlen   = 7'(vl);
    req_valid  = 1'b1;
    @(posedge clk);
    k = 0;
    last_wb = -1;
    ready_bad = 1'b0;
    got_done = 1'b0;
    for (int cyc = 0; cyc < 3000 && !got_done; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        if (hold_junk) begin
          req_base = 10'd999; req_stride = 10'd5; req_vlen = 7'd1;
        end else begin
          req_valid = 1'b0;
        end
      end
      if (wb_valid) begin
        if (k < n) begin
          check(wb_idx == 6'(k), "R5", {tag, " idx"}, wb_idx, k);
          check(wb_data == word_at(base + k * stride), "R6", {tag, " data (R2)"},
                wb_data, word_at(base + k * stride));
          check(cyc == exp_cnt[k], "R4", {tag, " timing (R3)"}, cyc, exp_cnt[k]);
        end else begin
          check(1'b0, "R9", {tag, " extra write-back"}, k, n);
        end
        k++;
        last_wb = cyc;
      end
      if (done) begin
        got_done = 1'b1;
        req_valid = 1'b0;
        check(req_ready == 1'b1, "R7", {tag, " ready with done"}, req_ready, 1);
        if (n == 0)
          check(cyc == 0, "R8", {tag, " zero-length done cycle"}, cyc, 0);
        else
          check(cyc == last_wb + 1, "R7", {tag, " done cycle"}, cyc, last_wb + 1);
      end else if (n > 0 && req_ready) begin
        ready_bad = 1'b1;
      end
    end
    check(got_done, "R7", {tag, " done seen"}, got_done, 1);
    check(k == n, "R5", {tag, " element count"}, k, n);
    if (n > 0)
      check(!ready_bad, "R1", {tag, " ready low while running"}, ready_bad, 0);
    else
      check(!ready_bad && req_ready, "R8", {tag, " ready held"}, req_ready, 1);
    @(negedge clk);
    check(!done && !wb_valid, "R7", {tag, " done single cycle"}, done, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    check(wb_valid == 1'b0, "R5", "reset wb_valid", wb_valid, 0);
    check(done == 1'b0, "R7", "reset done", done, 0);
  endtask

  task automatic t_unit_stride;  run_vec(100, 1, 16, 1'b0, "unit stride");     endtask
  // R10: same bank every element, junk request held on the bus (R1)
  task automatic t_stride16;     run_vec(7, 16, 5, 1'b1, "stride16 R10");      endtask
  task automatic t_stride8;      run_vec(0, 8, 6, 1'b0, "stride8 conflicts");  endtask
  task automatic t_negative;     run_vec(3, -1, 8, 1'b0, "negative wrap R2");  endtask
  task automatic t_zero_len;     run_vec(40, 1, 0, 1'b0, "zero length R8");    endtask
  task automatic t_clamp;        run_vec(0, 1, 70, 1'b0, "clamp R9");          endtask
  task automatic t_stride3_max;  run_vec(500, 3, 64, 1'b0, "stride3 full");    endtask
  task automatic t_stride0;      run_vec(21, 0, 4, 1'b0, "stride0 R10");       endtask

  // after a run with a held request, the junk must not have started a run
  task automatic t_junk_ignored;
    repeat (20) @(negedge clk);
    check(!wb_valid && !done && req_ready, "R1", "held request ignored",
          {wb_valid, done, req_ready}, 3'b001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unit_stride();
    t_stride16();
    t_junk_ignored();
    t_stride8();
    t_negative();
    t_zero_len();
    t_clamp();
    t_stride3_max();
    t_stride0();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule